// File: doc/BRIEF.md
# Keyboard Indicator Update Sequencer

This block updates the indicator lights of a PS/2 keyboard. On a start strobe it latches an LED pattern, hands the set-indicators command byte (0xED) to a byte transmitter below it and, once that byte has gone out, watches the stream of bytes received from the keyboard for a reply. An acknowledge (0xFA) that arrives in time lets it send the LED pattern as a second byte and wait for a second acknowledge. Any other outcome ends the command with failure: a reply byte other than 0xFA (resend 0xFE and echo 0xEE included), a missing reply, or an error reported by the transmitter. The bit-level line protocol lives in the transmitter. Deciding whether to retry is left to the user.

Received bytes are only examined while a reply is expected. A byte still in the receive stream from earlier traffic therefore cannot be taken as the answer to this command. The reply window is a cycle count, `TIMEOUT_CYCLES`, which the integrator sets to about 100 ms of the system clock.

States: `S_IDLE`, `S_ISSUE_CMD`, `S_XMIT_CMD`, `S_WAIT_CMD`, `S_ISSUE_LED`, `S_XMIT_LED`, `S_WAIT_LED`, `S_REPORT`. Transitions:
- `S_IDLE` goes to `S_ISSUE_CMD` on `go`.
- `S_ISSUE_CMD` goes to `S_XMIT_CMD` unconditionally.
- `S_XMIT_CMD` goes to `S_WAIT_CMD` on `tx_done`, or to `S_REPORT` (fail) on `tx_err`.
- `S_WAIT_CMD` goes to `S_ISSUE_LED` on an acknowledge. A different byte or a timeout sends it to `S_REPORT` (fail).
- `S_ISSUE_LED` goes to `S_XMIT_LED` unconditionally.
- `S_XMIT_LED` goes to `S_WAIT_LED` on `tx_done`, or to `S_REPORT` (fail) on `tx_err`.
- `S_WAIT_LED` goes to `S_REPORT` (pass) on an acknowledge. A different byte or a timeout sends it to `S_REPORT` (fail).
- `S_REPORT` goes to `S_IDLE` unconditionally.

Top module: `led_cmd_seq`

## Requirements
- R1: A `go` seen in `S_IDLE` latches `led_state`. In the next cycle `tx_start` is high for exactly one cycle with `tx_data` = 0xED.
- R2: A byte on `rx_valid` outside the two wait states has no effect. In particular, a stale 0xFA received while idle or while a byte is being sent does not count as a reply.
- R3: A reply of 0xFA to the command byte leads to one `tx_start` cycle with `tx_data` equal to the latched LED pattern, zero-extended to 8 bits (bit 0 = LED bit 0). A second 0xFA then gives `ok` = 1 at `done`.
- R4: Any reply byte other than 0xFA ends the command with `ok` = 0, including 0xFE and 0xEE, at either step.
- R5: A wait state accepts a reply whose `rx_valid` falls in its cycles 0 to `TIMEOUT_CYCLES`-1. With no reply, `done` with `ok` = 0 appears exactly `TIMEOUT_CYCLES` cycles after the cycle that sampled `tx_done`.
- R6: `tx_err` while either byte is being sent ends the command with `ok` = 0 and no further `tx_start`.
- R7: Every accepted `go` gives exactly one `done`, high for one cycle. `ok` is valid in that cycle.
- R8: `go` outside `S_IDLE` is ignored: the LED byte sent is the one latched at the accepted `go`, and no extra `done` follows.
- R9: After reset the block is idle, with `done` and `tx_start` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start strobe, honoured only when idle |
| led_state | input | LED_W | LED pattern to send |
| tx_start | output | 1 | One-cycle request to the byte transmitter |
| tx_data | output | 8 | Byte to transmit, valid with `tx_start` |
| tx_done | input | 1 | Transmitter finished the byte successfully |
| tx_err | input | 1 | Transmitter aborted the byte |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| done | output | 1 | One-cycle end-of-command pulse |
| ok | output | 1 | Command result, 1 = both bytes acknowledged |

## Verification
The assertions make several assumptions about the inputs:
- The transmitter answers each `tx_start` with exactly one `tx_done` or `tx_err` pulse, never both in one cycle, and only after the request.
- `rx_valid` is a single-cycle strobe for each byte.
- Inputs change only away from the sampling edge.

The bench models the transmitter and keyboard to respect these rules. It raises `tx_done`/`tx_err` a fixed two cycles after each request and places every reply byte at a chosen cycle offset inside or outside the reply window. Stale bytes and extra `go` strobes are injected only where R2 and R8 say they must be harmless.

// File: rtl/ledseq_pkg.sv
package ledseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE_CMD,
        S_XMIT_CMD,
        S_WAIT_CMD,
        S_ISSUE_LED,
        S_XMIT_LED,
        S_WAIT_LED,
        S_REPORT
    } seq_state_e;

    localparam logic [7:0] CODE_SET_LEDS = 8'hED;
    localparam logic [7:0] CODE_ACK      = 8'hFA;

endpackage

// File: rtl/reply_timer.sv
module reply_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Window restarts from zero every time run is dropped.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);

    // R5: every wait window begins with a fresh count
    p_fresh_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !$past(run)) |-> (cnt == '0));

endmodule

// File: rtl/reply_gate.sv
module reply_gate #(
    parameter logic [7:0] ACK_CODE = 8'hFA
) (
    input  logic       listen,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       got_ack,
    output logic       got_other
);
    logic taken;

    // Bytes outside a listening window are dropped here (stale flush).
    assign taken     = listen && rx_valid;
    assign got_ack   = taken && (rx_data == ACK_CODE);
    assign got_other = taken && (rx_data != ACK_CODE);

endmodule

// File: rtl/led_cmd_seq.sv
module led_cmd_seq
    import ledseq_pkg::*;
#(
    parameter int LED_W          = 3,
    parameter int TIMEOUT_CYCLES = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [LED_W-1:0] led_state,
    output logic             tx_start,
    output logic [7:0]       tx_data,
    input  logic             tx_done,
    input  logic             tx_err,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             done,
    output logic             ok
);
    seq_state_e       state, nxt;
    logic [LED_W-1:0] led_q;
    logic [7:0]       led_byte;
    logic             result_q, pass_d;
    logic             waiting, got_ack, got_other, expired;

    generate
        if (LED_W == 8) begin : g_full
            assign led_byte = led_q;
        end else begin : g_pad
            assign led_byte = {{(8-LED_W){1'b0}}, led_q};
        end
    endgenerate

    reply_gate #(.ACK_CODE(CODE_ACK)) u_gate (
        .listen    (waiting),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .got_ack   (got_ack),
        .got_other (got_other)
    );

    reply_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (waiting),
        .expired (expired)
    );

    // Next-state decision; a received byte wins over an expiring window.
    always_comb begin
        nxt    = state;
        pass_d = 1'b0;
        unique case (state)
            S_IDLE:      if (go) nxt = S_ISSUE_CMD;
            S_ISSUE_CMD: nxt = S_XMIT_CMD;
            S_XMIT_CMD: begin
                if (tx_err)       nxt = S_REPORT;
                else if (tx_done) nxt = S_WAIT_CMD;
            end
            S_WAIT_CMD: begin
                if (got_ack)                   nxt = S_ISSUE_LED;
                else if (got_other || expired) nxt = S_REPORT;
            end
            S_ISSUE_LED: nxt = S_XMIT_LED;
            S_XMIT_LED: begin
                if (tx_err)       nxt = S_REPORT;
                else if (tx_done) nxt = S_WAIT_LED;
            end
            S_WAIT_LED: begin
                if (got_ack) begin
                    nxt    = S_REPORT;
                    pass_d = 1'b1;
                end else if (got_other || expired) begin
                    nxt = S_REPORT;
                end
            end
            S_REPORT:    nxt = S_IDLE;
        endcase
    end

    // State register with the LED latch and the result flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            led_q    <= '0;
            result_q <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && go) begin
                led_q    <= led_state;
                result_q <= 1'b0;
            end
            if (state != S_REPORT && nxt == S_REPORT) begin
                result_q <= pass_d;
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        tx_start = (state == S_ISSUE_CMD) || (state == S_ISSUE_LED);
        tx_data  = (state == S_ISSUE_LED) ? led_byte : CODE_SET_LEDS;
        waiting  = (state == S_WAIT_CMD) || (state == S_WAIT_LED);
        done     = (state == S_REPORT);
        ok       = result_q;
    end

    // R1: a request lasts exactly one cycle
    p_start_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    // R1: an accepted go is followed by the command byte request
    p_first_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && go) |=> (tx_start && tx_data == CODE_SET_LEDS));

    // R3: success only directly after an acknowledge to the LED byte
    p_ok_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok) |-> $past(state == S_WAIT_LED && rx_valid && rx_data == CODE_ACK));

    // R4: a non-acknowledge reply fails the command at once
    p_nack_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && rx_valid && rx_data != CODE_ACK) |=> (done && !ok));

    // R5: an empty window ends in failure
    p_timeout_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && expired && !rx_valid) |=> (done && !ok));

    // R6: transmitter error fails the command
    p_err_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_XMIT_CMD || state == S_XMIT_LED) && tx_err) |=> (done && !ok));

    // R7: done is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the latched pattern holds while a command is running
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> $stable(led_q));

endmodule

// File: tb/tb_led_cmd_seq.sv
module tb_led_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TO         = 40;
    localparam int LW         = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          go = 1'b0;
    logic [LW-1:0] led_in = '0;
    logic          tx_start;
    logic [7:0]    tx_data;
    logic          tx_done = 1'b0;
    logic          tx_err = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = 8'h00;
    logic          done;
    logic          ok;

    int n_chk = 0;
    int n_err = 0;
    bit    q_ok[$];
    string q_tag[$];

    led_cmd_seq #(.LED_W(LW), .TIMEOUT_CYCLES(TO)) dut (
        .clk(clk), .rst_n(rst_n), .go(go), .led_state(led_in),
        .tx_start(tx_start), .tx_data(tx_data), .tx_done(tx_done), .tx_err(tx_err),
        .rx_valid(rx_valid), .rx_data(rx_data), .done(done), .ok(ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit c, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!c) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: every done pops one expected result.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q_ok.size() == 0) begin
                check(1'b0, "R7", "unexpected done", 1, 0);
            end else begin
                bit    e;
                string t;
                e = q_ok.pop_front();
                t = q_tag.pop_front();
                check(ok == e, "R7", t, int'(ok), int'(e));
            end
        end
    end

    task automatic wait_start(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (tx_start) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic wait_done(output int k);
        int starts;
        k = 0;
        starts = 0;
        while (!done && k < 300) begin
            @(negedge clk);
            k++;
            if (tx_start) starts++;
        end
        check(starts == 0, "R6", "no request after end of command", starts, 0);
    endtask

    task automatic send_outcome(input bit err);
        @(negedge clk);
        if (err) tx_err = 1'b1; else tx_done = 1'b1;
        @(negedge clk);
        tx_err  = 1'b0;
        tx_done = 1'b0;
    endtask

    task automatic give_reply(input logic [7:0] r, input int d);
        repeat (d) @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = r;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // One step: outcome of the send, then the reply; returns 1 if the step passed.
    task automatic run_step(input bit e, input logic [7:0] r, input int d,
                            input string tag, output bit pass);
        int k;
        pass = !e && d >= 0 && d <= TO-1 && r == 8'hFA;
        send_outcome(e);
        if (e) begin
            wait_done(k);
        end else if (d < 0 || d >= TO) begin
            wait_done(k);
            check(k == TO, "R5", {tag, " timeout latency"}, k, TO);
            if (d >= 0) begin
                give_reply(r, 0);
                repeat (4) @(negedge clk);
            end
        end else begin
            give_reply(r, d);
            if (!pass) wait_done(k);
        end
    endtask

    task automatic run_cmd(input logic [LW-1:0] led,
                           input bit e1, input logic [7:0] r1, input int d1,
                           input bit e2, input logic [7:0] r2, input int d2,
                           input bit busy_go, input bit stale, input string tag);
        bit s1, s2, seen;
        int k;
        s1 = !e1 && d1 >= 0 && d1 <= TO-1 && r1 == 8'hFA;
        s2 = !e2 && d2 >= 0 && d2 <= TO-1 && r2 == 8'hFA;
        q_ok.push_back(s1 && s2);
        q_tag.push_back(tag);
        @(negedge clk);
        go = 1'b1;
        led_in = led;
        @(negedge clk);
        go = 1'b0;
        wait_start(seen);
        check(seen && tx_data == 8'hED, "R1", {tag, " command byte"}, int'(tx_data), 'hED);
        if (stale) begin
            rx_valid = 1'b1;
            rx_data  = 8'hFA;
        end
        @(negedge clk);
        rx_valid = 1'b0;
        if (busy_go) begin
            go = 1'b1;
            led_in = ~led;
        end
        run_step(e1, r1, d1, tag, s1);
        go = 1'b0;
        if (!s1) return;
        wait_start(seen);
        check(seen && tx_data == {{(8-LW){1'b0}}, led}, busy_go ? "R8" : "R3",
              {tag, " LED byte"}, int'(tx_data), int'({{(8-LW){1'b0}}, led}));
        @(negedge clk);
        run_step(e2, r2, d2, tag, s2);
        if (s2) wait_done(k);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R7", "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !tx_start, "R9", "reset state", int'({done, tx_start}), 0);

        // R3 R7: straight success paths, including window edges
        run_cmd(3'b101, 0, 8'hFA, 0,    0, 8'hFA, 0,    0, 0, "R3 immediate acks");
        run_cmd(3'b010, 0, 8'hFA, 5,    0, 8'hFA, TO-1, 0, 0, "R5 ack at last window cycle step2");
        run_cmd(3'b111, 0, 8'hFA, TO-1, 0, 8'hFA, 7,    0, 0, "R5 ack at last window cycle step1");
        run_cmd(3'b000, 0, 8'hFA, 2,    0, 8'hFA, 3,    0, 0, "R3 zero pattern");
        // R5: late reply and missing reply
        run_cmd(3'b011, 0, 8'hFA, TO,   0, 8'hFA, 0,    0, 0, "R5 late reply step1");
        run_cmd(3'b011, 0, 8'hFA, 1,    0, 8'hFA, -1,   0, 0, "R5 no reply step2");
        // R4: non-acknowledge bytes
        run_cmd(3'b001, 0, 8'hFE, 3,    0, 8'hFA, 0,    0, 0, "R4 resend at step1");
        run_cmd(3'b100, 0, 8'hFA, 3,    0, 8'hEE, 2,    0, 0, "R4 echo at step2");
        run_cmd(3'b110, 0, 8'hFA, 0,    0, 8'h00, 9,    0, 0, "R4 zero byte at step2");
        // R6: transmitter errors
        run_cmd(3'b101, 1, 8'hFA, 0,    0, 8'hFA, 0,    0, 0, "R6 error on command byte");
        run_cmd(3'b101, 0, 8'hFA, 4,    1, 8'hFA, 0,    0, 0, "R6 error on LED byte");
        // R2: stale acknowledge while idle and during issue must not count
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = 8'hFA;
        @(negedge clk);
        rx_valid = 1'b0;
        run_cmd(3'b010, 0, 8'hFA, -1,   0, 8'hFA, 0,    0, 1, "R2 stale bytes ignored");
        // R8: go during a running command
        run_cmd(3'b001, 0, 8'hFA, 6,    0, 8'hFA, 1,    1, 0, "R8 busy go ignored");

        repeat (5) @(negedge clk);
        check(q_ok.size() == 0, "R7", "one done per command", q_ok.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule